// File: doc/BRIEF.md
# Channel Status Triple Block Buffer

This block carries AES3-style channel status bits from a receive timebase to a transmit timebase one whole block at a time. Bits enter a capture store from a serial stream. Each bit is tagged with its subframe (A or B), and a marker flags the first frame of a block. After the last of the 192 frames of a block arrives, the captured block moves as a unit into a middle store. The middle store is mapped into a small register space, so the host can inspect it and overwrite it. At the start of each transmit block the middle store is copied as a unit into an output store. The transmitter then pulls bits from the output store one request at a time.

Each of the two transfers raises a sticky flag. The flags are combined with per-flag enables to drive one interrupt line, which tells the host when it is safe to access the middle store. Each transfer also has its own inhibit control. An inhibited transfer is skipped at that instant and does not happen later. Each store holds 24 bytes per subframe. Within a byte the bits are ordered MSB first, so bit 7 of byte 0 is frame 0, the first bit of the block.

Top module: `csb_cascade`

## Requirements
- R1: After reset all three stores, the control register and both flags are zero. `irq_o` and `tx_valid_o` are low, and every register address reads 0.
- R2: Every cycle with `tx_req_i` high is answered on the next cycle by `tx_valid_o` high. `tx_bit_o` then carries the output-store bit for the current frame and the subframe named by `tx_sub_b_i` (0=A, 1=B). Frame f maps to byte f/8, bit 7-(f mod 8). The frame number starts at 0 on a request with `tx_start_i` and advances after each subframe-B request.
- R3: Capture starts on an `rx_valid_i` bit with `rx_start_i` high and `rx_sub_b_i` low. On the cycle after the subframe-B bit of frame 191 is captured, the whole captured block is copied into the middle store.
- R4: Register address 1 holds flags. Bit 0 is set by a capture-to-middle transfer and bit 1 by a middle-to-output transfer. Writing a 1 to a bit clears it, and a set in the same cycle wins over the clear.
- R5: `irq_o` is high exactly when some flag is set and its enable is set. Enables are control register (address 0) bit 2 for flag bit 0 and bit 3 for flag bit 1.
- R6: While control bit 0 is set at the transfer instant, the capture-to-middle transfer and its flag are skipped. Clearing the bit later does not bring the transfer back.
- R7: A request with `tx_start_i` high copies the middle store into the output store unless control bit 1 is set. The bit returned for that request already comes from the newly copied block. An inhibited start leaves the output store and flag bit 1 unchanged.
- R8: Middle-store byte n of subframe A is at address 32+2n and of subframe B at 33+2n (n = 0..23). Both are readable and writable. Address 0 reads back control bits [3:0]. `reg_rdata_o` is registered from the address presented on the previous cycle, and unmapped addresses read 0 and ignore writes.
- R9: A host write to the middle store in the same cycle as a capture-to-middle transfer is lost, and the transferred block is stored.
- R10: A start marker that arrives before a block completes restarts capture at frame 0 and discards the partial block. A block that never completes is never transferred.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_valid_i | input | 1 | Receive C bit strobe |
| rx_sub_b_i | input | 1 | Receive bit subframe: 0=A, 1=B |
| rx_bit_i | input | 1 | Receive C bit value |
| rx_start_i | input | 1 | Receive block-start marker (with frame 0, subframe A) |
| tx_req_i | input | 1 | Transmit bit request |
| tx_sub_b_i | input | 1 | Requested subframe: 0=A, 1=B |
| tx_start_i | input | 1 | Transmit block start (first request of block) |
| tx_valid_o | output | 1 | Transmit bit valid, one cycle after request |
| tx_bit_o | output | 1 | Transmit C bit |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 7 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Registered read data |
| irq_o | output | 1 | Interrupt request |

## Verification
A wrong capture counter or bit-order mapping shows up two cycles after the last receive bit of a block, as mismatching bytes in a sweep of the middle store. A wrong output-store load or transmit frame counter changes `tx_bit_o` on the next cycle after the faulty request, so the bit-by-bit scoreboard catches it within one frame. A wrong transfer gate or inhibit shows up in the flags, in `irq_o`, or in a middle store that changed when it should not have. Each of these is visible on the next register read after the transfer instant.

// File: rtl/csb_pkg.sv
package csb_pkg;
  localparam int FRAMES = 192;
  localparam int BYTE_W = 8;
  localparam int WORDS  = FRAMES / BYTE_W;
  localparam int FIDX_W = $clog2(FRAMES);
  localparam int WORD_W = $clog2(WORDS);
  localparam int ADDR_W = 7;
  localparam int DATA_W = 8;
  localparam int E_BASE = 32;
  localparam int CTRL_W = 4;
  localparam int FLAG_W = 2;

  typedef logic [WORDS-1:0][BYTE_W-1:0] chan_t;
  typedef struct packed {
    chan_t a;
    chan_t b;
  } blk_t;

  // MSB of each byte is the earliest frame
  function automatic blk_t put_bit(blk_t blk, logic [FIDX_W-1:0] idx, logic ch, logic v);
    blk_t r;
    logic [WORD_W-1:0] w;
    logic [2:0] p;
    r = blk;
    w = idx[FIDX_W-1:3];
    p = 3'd7 - idx[2:0];
    if (ch) r.b[w][p] = v;
    else    r.a[w][p] = v;
    return r;
  endfunction

  function automatic logic get_bit(blk_t blk, logic [FIDX_W-1:0] idx, logic ch);
    logic [WORD_W-1:0] w;
    logic [2:0] p;
    w = idx[FIDX_W-1:3];
    p = 3'd7 - idx[2:0];
    return ch ? blk.b[w][p] : blk.a[w][p];
  endfunction
endpackage

// File: rtl/csb_capture.sv
module csb_capture
  import csb_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  input  logic sub_b_i,
  input  logic bit_i,
  input  logic start_i,
  output blk_t blk_o,
  output logic done_o
);
  localparam logic [FIDX_W-1:0] LAST = FIDX_W'(FRAMES - 1);

  blk_t              blk_q;
  logic [FIDX_W-1:0] cnt_q;
  logic              act_q;
  logic              done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      blk_q  <= '0;
      cnt_q  <= '0;
      act_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (valid_i) begin
        if (start_i && !sub_b_i) begin
          // restart discards any partial block
          blk_q <= put_bit(blk_q, '0, 1'b0, bit_i);
          cnt_q <= '0;
          act_q <= 1'b1;
        end else if (act_q) begin
          blk_q <= put_bit(blk_q, cnt_q, sub_b_i, bit_i);
          if (sub_b_i) begin
            if (cnt_q == LAST) begin
              cnt_q  <= '0;
              act_q  <= 1'b0;
              done_q <= 1'b1;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
      end
    end
  end

  assign blk_o  = blk_q;
  assign done_o = done_q;
endmodule

// File: rtl/csb_mid.sv
module csb_mid
  import csb_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  blk_t              blk_i,
  input  logic              we_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              ch_i,
  input  logic [DATA_W-1:0] wdata_i,
  output blk_t              blk_o
);
  blk_t blk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      blk_q <= '0;
    end else if (load_i) begin
      blk_q <= blk_i;   // block transfer beats host write
    end else if (we_i) begin
      if (ch_i) blk_q.b[word_i] <= wdata_i;
      else      blk_q.a[word_i] <= wdata_i;
    end
  end

  assign blk_o = blk_q;
endmodule

// File: rtl/csb_emit.sv
module csb_emit
  import csb_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic sub_b_i,
  input  logic start_i,
  input  logic inh_i,
  input  blk_t blk_i,
  output logic xfer_o,
  output logic valid_o,
  output logic bit_o
);
  localparam logic [FIDX_W-1:0] LAST = FIDX_W'(FRAMES - 1);

  blk_t              blk_q;
  logic [FIDX_W-1:0] cnt_q;
  logic              valid_q;
  logic              bit_q;
  logic              xfer;
  logic [FIDX_W-1:0] idx;
  blk_t              src;

  assign xfer = req_i && start_i && !inh_i;
  assign idx  = start_i ? '0 : cnt_q;
  assign src  = xfer ? blk_i : blk_q;   // bypass so frame 0 uses the new block

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      blk_q   <= '0;
      cnt_q   <= '0;
      valid_q <= 1'b0;
      bit_q   <= 1'b0;
    end else begin
      valid_q <= req_i;
      if (xfer) blk_q <= blk_i;
      if (req_i) begin
        bit_q <= get_bit(src, idx, sub_b_i);
        if (sub_b_i) cnt_q <= (idx == LAST) ? '0 : idx + 1'b1;
        else         cnt_q <= idx;
      end
    end
  end

  assign xfer_o  = xfer;
  assign valid_o = valid_q;
  assign bit_o   = bit_q;
endmodule

// File: rtl/csb_regs.sv
module csb_regs
  import csb_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              de_set_i,
  input  logic              ef_set_i,
  input  blk_t              blk_i,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic [FLAG_W-1:0] flags_o,
  output logic              e_we_o,
  output logic [WORD_W-1:0] e_word_o,
  output logic              e_ch_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_FLAG = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_LO   = ADDR_W'(E_BASE);
  localparam logic [ADDR_W-1:0] A_HI   = ADDR_W'(E_BASE + 2 * WORDS);

  logic [CTRL_W-1:0] ctrl_q;
  logic [FLAG_W-1:0] flag_q;
  logic [DATA_W-1:0] rdata_q;
  logic [ADDR_W-1:0] off;
  logic              in_e;
  logic [FLAG_W-1:0] set_v;
  logic [FLAG_W-1:0] clr_v;
  logic [DATA_W-1:0] rd_mux;
  logic [WORD_W-1:0] word;

  assign off   = addr_i - A_LO;
  assign in_e  = (addr_i >= A_LO) && (addr_i < A_HI);
  assign word  = off[WORD_W:1];
  assign set_v = {ef_set_i, de_set_i};
  assign clr_v = (we_i && addr_i == A_FLAG) ? wdata_i[FLAG_W-1:0] : '0;

  always_comb begin
    rd_mux = '0;
    if (addr_i == A_CTRL)      rd_mux = DATA_W'(ctrl_q);
    else if (addr_i == A_FLAG) rd_mux = DATA_W'(flag_q);
    else if (in_e)             rd_mux = off[0] ? blk_i.b[word] : blk_i.a[word];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      flag_q  <= '0;
      rdata_q <= '0;
    end else begin
      rdata_q <= rd_mux;
      if (we_i && addr_i == A_CTRL) ctrl_q <= wdata_i[CTRL_W-1:0];
      flag_q <= set_v | (flag_q & ~clr_v);
    end
  end

  assign ctrl_o   = ctrl_q;
  assign flags_o  = flag_q;
  assign e_we_o   = we_i && in_e;
  assign e_word_o = word;
  assign e_ch_o   = off[0];
  assign rdata_o  = rdata_q;
  assign irq_o    = |(flag_q & ctrl_q[CTRL_W-1:FLAG_W]);
endmodule

// File: rtl/csb_cascade.sv
module csb_cascade
  import csb_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_valid_i,
  input  logic              rx_sub_b_i,
  input  logic              rx_bit_i,
  input  logic              rx_start_i,
  input  logic              tx_req_i,
  input  logic              tx_sub_b_i,
  input  logic              tx_start_i,
  output logic              tx_valid_o,
  output logic              tx_bit_o,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_o
);
  blk_t              d_blk;
  blk_t              e_blk;
  logic              cap_done;
  logic              de_load;
  logic              ef_xfer;
  logic [CTRL_W-1:0] ctrl;
  logic [FLAG_W-1:0] flags;
  logic              e_we;
  logic [WORD_W-1:0] e_word;
  logic              e_ch;

  assign de_load = cap_done && !ctrl[0];

  csb_capture u_cap (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (rx_valid_i),
    .sub_b_i (rx_sub_b_i),
    .bit_i   (rx_bit_i),
    .start_i (rx_start_i),
    .blk_o   (d_blk),
    .done_o  (cap_done)
  );

  csb_mid u_mid (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (de_load),
    .blk_i   (d_blk),
    .we_i    (e_we),
    .word_i  (e_word),
    .ch_i    (e_ch),
    .wdata_i (reg_wdata_i),
    .blk_o   (e_blk)
  );

  csb_emit u_emit (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (tx_req_i),
    .sub_b_i (tx_sub_b_i),
    .start_i (tx_start_i),
    .inh_i   (ctrl[1]),
    .blk_i   (e_blk),
    .xfer_o  (ef_xfer),
    .valid_o (tx_valid_o),
    .bit_o   (tx_bit_o)
  );

  csb_regs u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (reg_we_i),
    .addr_i   (reg_addr_i),
    .wdata_i  (reg_wdata_i),
    .de_set_i (de_load),
    .ef_set_i (ef_xfer),
    .blk_i    (e_blk),
    .ctrl_o   (ctrl),
    .flags_o  (flags),
    .e_we_o   (e_we),
    .e_word_o (e_word),
    .e_ch_o   (e_ch),
    .rdata_o  (reg_rdata_o),
    .irq_o    (irq_o)
  );
endmodule

// File: rtl/csb_cascade_chk.sv
module csb_cascade_chk
  import csb_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cap_done,
  input logic              e_we,
  input blk_t              d_blk,
  input blk_t              e_blk,
  input logic              ef_xfer,
  input logic [CTRL_W-1:0] ctrl,
  input logic [FLAG_W-1:0] flags,
  input logic              tx_req_i,
  input logic              tx_valid_o,
  input logic              irq_o
);
  a_r2_tx_answer: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_req_i |=> tx_valid_o);

  a_r2_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_req_i |=> !tx_valid_o);

  // R3 and R9: the whole captured block lands even with a host write
  a_r3_whole_block: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_done && !ctrl[0]) |=> (e_blk == $past(d_blk)));

  a_r4_de_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_done && !ctrl[0]) |=> flags[0]);

  a_r4_ef_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ef_xfer |=> flags[1]);

  a_r5_irq_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl[3:2] == 2'b00) |-> !irq_o);

  a_r6_inhibit_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_done && ctrl[0] && !e_we) |=> $stable(e_blk));

  a_r6_no_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_done && ctrl[0] && !flags[0] && !e_we) |=> !flags[0]);
endmodule

bind csb_cascade csb_cascade_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cap_done   (cap_done),
  .e_we       (e_we),
  .d_blk      (d_blk),
  .e_blk      (e_blk),
  .ef_xfer    (ef_xfer),
  .ctrl       (ctrl),
  .flags      (flags),
  .tx_req_i   (tx_req_i),
  .tx_valid_o (tx_valid_o),
  .irq_o      (irq_o)
);

// File: tb/csb_cascade_test.sv
`timescale 1ns/1ps
module csb_cascade_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       rx_valid_i = 0, rx_sub_b_i = 0, rx_bit_i = 0, rx_start_i = 0;
  logic       tx_req_i = 0, tx_sub_b_i = 0, tx_start_i = 0;
  logic       tx_valid_o, tx_bit_o;
  logic       reg_we_i = 0;
  logic [6:0] reg_addr_i = '0;
  logic [7:0] reg_wdata_i = '0;
  logic [7:0] reg_rdata_o;
  logic       irq_o;

  int errors = 0;
  int checks = 0;
  bit exp_q[$];
  logic [7:0] me [2][24];
  logic [7:0] mf [2][24];
  logic [3:0] ctl = '0;
  logic [7:0] rd;

  always #2 clk_i = ~clk_i;

  csb_cascade uut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit pat(int sel, int f, int ch);
    return ((f * 13 + ch * 7 + sel * 29) % 5) < 2;
  endfunction

  function automatic logic [7:0] pat_byte(int sel, int n, int ch);
    logic [7:0] b;
    for (int k = 0; k < 8; k++) b[7-k] = pat(sel, 8 * n + k, ch);
    return b;
  endfunction

  task automatic reg_write(input logic [6:0] a, input logic [7:0] d);
    @(posedge clk_i); #1;
    reg_we_i = 1; reg_addr_i = a; reg_wdata_i = d;
    @(posedge clk_i); #1;
    reg_we_i = 0;
    if (a == 0) ctl = d[3:0];
    if (a >= 32 && a < 80) me[(a - 32) % 2][(a - 32) / 2] = d;
  endtask

  task automatic reg_read(input logic [6:0] a, output logic [7:0] d);
    @(posedge clk_i); #1;
    reg_addr_i = a;
    @(posedge clk_i); #1;
    d = reg_rdata_o;
  endtask

  task automatic check_e(input string req);
    for (int n = 0; n < 24; n++) begin
      for (int ch = 0; ch < 2; ch++) begin
        reg_read(7'(32 + 2 * n + ch), rd);
        chk(rd == me[ch][n], req, rd, me[ch][n]);
      end
    end
  endtask

  // scoreboard driver: expected bits pushed at request time
  task automatic tx_block();
    if (!ctl[1]) mf = me;
    for (int f = 0; f < 192; f++) begin
      for (int ch = 0; ch < 2; ch++) begin
        @(posedge clk_i); #1;
        tx_req_i = 1; tx_sub_b_i = ch[0]; tx_start_i = (f == 0 && ch == 0);
        exp_q.push_back(mf[ch][f / 8][7 - (f % 8)]);
      end
    end
    @(posedge clk_i); #1;
    tx_req_i = 0; tx_start_i = 0;
    @(posedge clk_i); #1;
  endtask

  // collide: host write to address 32 in the transfer cycle
  task automatic rx_frames(input int sel, input int nfr, input bit collide);
    for (int f = 0; f < nfr; f++) begin
      for (int ch = 0; ch < 2; ch++) begin
        @(posedge clk_i); #1;
        rx_valid_i = 1; rx_sub_b_i = ch[0]; rx_bit_i = pat(sel, f, ch);
        rx_start_i = (f == 0 && ch == 0);
      end
    end
    @(posedge clk_i); #1;
    rx_valid_i = 0; rx_start_i = 0;
    if (collide) begin
      reg_we_i = 1; reg_addr_i = 7'd32; reg_wdata_i = 8'hA5;
    end
    @(posedge clk_i); #1;
    reg_we_i = 0;
    if (nfr == 192 && !ctl[0])
      for (int n = 0; n < 24; n++)
        for (int ch = 0; ch < 2; ch++) me[ch][n] = pat_byte(sel, n, ch);
    @(posedge clk_i); #1;
  endtask

  // scoreboard monitor
  always @(negedge clk_i) begin
    if (rst_ni && tx_valid_o) begin
      if (exp_q.size() == 0) begin
        chk(0, "R2 unexpected bit", tx_bit_o, 0);
      end else begin
        bit e;
        e = exp_q.pop_front();
        chk(tx_bit_o == e, "R2/R7 tx bit", tx_bit_o, e);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    chk(0, "watchdog", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int ch = 0; ch < 2; ch++)
      for (int n = 0; n < 24; n++) begin me[ch][n] = 0; mf[ch][n] = 0; end
    repeat (3) @(posedge clk_i); #1;
    rst_ni = 1;
    // R1 reset state
    chk(tx_valid_o == 0, "R1 tx_valid", tx_valid_o, 0);
    chk(irq_o == 0, "R1 irq", irq_o, 0);
    reg_read(7'd0, rd);  chk(rd == 0, "R1 ctrl", rd, 0);
    reg_read(7'd1, rd);  chk(rd == 0, "R1 flags", rd, 0);
    reg_read(7'd32, rd); chk(rd == 0, "R1 store", rd, 0);
    reg_read(7'd79, rd); chk(rd == 0, "R1 store end", rd, 0);

    // R8 control and unmapped
    reg_write(7'd0, 8'h0C);
    reg_read(7'd0, rd); chk(rd == 8'h0C, "R8 ctrl readback", rd, 8'h0C);
    reg_write(7'd5, 8'hFF);
    reg_read(7'd5, rd); chk(rd == 0, "R8 unmapped", rd, 0);
    reg_write(7'd80, 8'hFF);
    reg_read(7'd80, rd); chk(rd == 0, "R8 past end", rd, 0);

    // R8 host fills middle store
    for (int n = 0; n < 24; n++) begin
      reg_write(7'(32 + 2 * n), 8'(n * 37 + 5));
      reg_write(7'(33 + 2 * n), 8'(n * 91 + 3));
    end
    check_e("R8 store readback");

    // R7 R2 transmit host data
    tx_block();
    reg_read(7'd1, rd); chk(rd == 8'h02, "R4 ef flag", rd, 2);
    chk(irq_o == 1, "R5 irq ef", irq_o, 1);
    reg_write(7'd1, 8'h02);
    reg_read(7'd1, rd); chk(rd == 0, "R4 w1c", rd, 0);
    chk(irq_o == 0, "R5 irq cleared", irq_o, 0);

    // R3 receive block
    rx_frames(1, 192, 0);
    reg_read(7'd1, rd); chk(rd == 8'h01, "R4 de flag", rd, 1);
    chk(irq_o == 1, "R5 irq de", irq_o, 1);
    check_e("R3 captured block");
    reg_write(7'd1, 8'h01);

    // R5 masked
    reg_write(7'd0, 8'h00);
    rx_frames(2, 192, 0);
    reg_read(7'd1, rd); chk(rd == 8'h01, "R5 flag w/o enable", rd, 1);
    chk(irq_o == 0, "R5 irq masked", irq_o, 0);
    reg_write(7'd1, 8'h03);
    check_e("R3 second block");

    // R6 inhibit, not deferred
    reg_write(7'd0, 8'h01);
    rx_frames(3, 192, 0);
    reg_read(7'd1, rd); chk(rd == 0, "R6 no flag", rd, 0);
    reg_write(7'd0, 8'h00);
    repeat (5) @(posedge clk_i); #1;
    reg_read(7'd1, rd); chk(rd == 0, "R6 not deferred flag", rd, 0);
    check_e("R6 store unchanged");

    // R10 restart and incomplete block
    rx_frames(4, 50, 0);
    rx_frames(5, 192, 0);
    check_e("R10 restart block");
    reg_write(7'd1, 8'h03);
    rx_frames(6, 100, 0);
    repeat (4) @(posedge clk_i); #1;
    reg_read(7'd1, rd); chk(rd == 0, "R10 no transfer", rd, 0);
    check_e("R10 partial discarded");

    // R7 inhibited transmit transfer
    reg_write(7'd0, 8'h02);
    tx_block();
    reg_read(7'd1, rd); chk(rd == 0, "R7 inhibited flag", rd, 0);
    reg_write(7'd0, 8'h00);
    tx_block();
    reg_read(7'd1, rd); chk(rd == 8'h02, "R7 flag after enable", rd, 2);

    // R9 collision
    rx_frames(7, 192, 1);
    reg_read(7'd32, rd);
    chk(rd == pat_byte(7, 0, 0), "R9 transfer wins", rd, pat_byte(7, 0, 0));
    check_e("R9 block intact");
    reg_write(7'd32, 8'h3C);
    reg_read(7'd32, rd); chk(rd == 8'h3C, "R8 write after", rd, 8'h3C);

    repeat (3) @(posedge clk_i); #1;
    chk(exp_q.size() == 0, "R2 all bits returned", exp_q.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule